// File: doc/BRIEF.md
# Raster Frame Timing Generator

This block turns a free-running pixel clock into a raster position: a dot counter that walks across each line and a line counter that walks down the frame. The default geometry is 262 lines of 341 dots, one dot per clock. From the position it derives four mutually exclusive region flags: the lines that show pixels, a single idle line after them, the blanking lines, and a final pre-render line on which fetch logic prepares the next frame.

A small state machine tracks the region. Its states are VISIBLE, POSTIDLE, VBLANK and PRERENDER. It has four transitions, each taken at the end of a line: VISIBLE to POSTIDLE after line 239, POSTIDLE to VBLANK after line 240, VBLANK to PRERENDER after line 260, and PRERENDER to VISIBLE after line 261, which is where the frame wraps. The block keeps a frame-parity bit. On odd frames with rendering enabled, the last dot of the pre-render line is dropped, so frame lengths alternate between 89342 and 89341 clocks. A vertical-blank flag is raised early in the first blanking line. It drives an interrupt request that can be masked. A divide-by-three enable gives a processor clock tick, so a line spans 113 and two-thirds ticks.

The geometry is set by parameters. The bench also runs a reduced geometry of 12 lines by 20 dots with 6 shown lines, which lets it cover several frames quickly.

Top module: `raster_timing_gen`

## Requirements
- R1: In a line, `dot` rises by one each clock. `line` changes only as `dot` returns to 0. Line 261 wraps to line 0.
- R2: `is_visible` is high exactly on lines 0 to 239. Exactly one of the four region flags is high in every cycle.
- R3: `is_postidle` is high only on line 240.
- R4: `is_vblank` is high exactly on lines 241 to 260.
- R5: `is_prerender` is high only on line 261.
- R6: When `odd_frame`=1 and `render_en`=1, the pre-render line ends at dot 339, and the next cycle shows line 0 dot 0.
- R7: On even frames, or whenever `render_en`=0, the pre-render line reaches dot 340.
- R8: `odd_frame` toggles each time line 261 wraps to line 0.
- R9: `vblank_flag` reads 1 from the cycle after the counters show line 241 dot 1. It returns to 0 in the cycle after the counters show line 261 dot 1.
- R10: If `flag_clr` is high in a cycle, `vblank_flag` reads 0 in the next cycle. The one exception is the setting position (line 241 dot 1), where setting wins.
- R11: `irq` equals `vblank_flag` when `irq_en`=1 and is 0 when `irq_en`=0. `irq_en` acts without delay.
- R12: `cpu_tick` is high in cycles 0, 3, 6 and so on after reset is released, which is one clock in three.
- R13: While `rst_n`=0, the outputs show line 0 dot 0, region VISIBLE, `vblank_flag`=0, `irq`=0, `odd_frame`=0 and `cpu_tick`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| render_en | input | 1 | Rendering enabled; permits the odd-frame dot skip |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | Strobe that clears the blanking flag |
| dot | output | DOT_W (9) | Dot position within the line |
| line | output | LINE_W (9) | Line number within the frame |
| is_visible | output | 1 | Shown-pixel line |
| is_postidle | output | 1 | Idle line after the shown lines |
| is_vblank | output | 1 | Blanking line |
| is_prerender | output | 1 | Pre-render line |
| vblank_flag | output | 1 | Vertical-blank flag |
| irq | output | 1 | Interrupt request |
| odd_frame | output | 1 | Frame parity, 1 on odd frames |
| cpu_tick | output | 1 | Processor clock enable, one clock in three |

## Verification
Some properties are checked on every cycle. These are the dot stepping and line stability inside a line, the one-hot region flags, and the line number that each region allows. They also cover the choice at dot 339 of the pre-render line between skipping and continuing, the parity flip at the frame wrap, the clear strobe, the interrupt implying the flag, and the tick spacing. The bench alone shows absolute positions, since these need counting from reset. That covers where the flag sets and clears inside a frame, the reset values, and the tick phase. It also covers the alternating frame lengths across several frames of the reduced geometry, with rendering on and then off.

// File: rtl/raster_pkg.sv
package raster_pkg;
    typedef enum logic [1:0] {
        RG_VISIBLE   = 2'd0,
        RG_POSTIDLE  = 2'd1,
        RG_VBLANK    = 2'd2,
        RG_PRERENDER = 2'd3
    } region_t;
endpackage

// File: rtl/raster_pos_ctr.sv
module raster_pos_ctr #(
    parameter int P_DOTS  = 341,
    parameter int P_LINES = 262,
    parameter int DOT_W   = 9,
    parameter int LINE_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              skip_last,
    output logic [DOT_W-1:0]  dot,
    output logic [LINE_W-1:0] line,
    output logic              line_end,
    output logic              odd_frame
);
    localparam logic [DOT_W-1:0]  LAST_DOT  = DOT_W'(P_DOTS - 1);
    localparam logic [DOT_W-1:0]  SKIP_DOT  = DOT_W'(P_DOTS - 2);
    localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(P_LINES - 1);

    logic frame_end;

    // A line closes at its last dot, or one dot early when a skip is allowed
    assign line_end  = (dot == LAST_DOT) || (skip_last && (dot == SKIP_DOT));
    assign frame_end = line_end && (line == LAST_LINE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dot       <= '0;
            line      <= '0;
            odd_frame <= 1'b0;
        end else begin
            if (line_end) begin
                dot  <= '0;
                line <= frame_end ? '0 : line + LINE_W'(1);
            end else begin
                dot <= dot + DOT_W'(1);
            end
            if (frame_end)
                odd_frame <= ~odd_frame;
        end
    end
endmodule

// File: rtl/raster_cpu_div.sv
module raster_cpu_div #(
    parameter int P_DIV = 3
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int PH_W = (P_DIV > 2) ? $clog2(P_DIV) : 1;
    localparam logic [PH_W-1:0] LAST_PH = PH_W'(P_DIV - 1);

    logic [PH_W-1:0] phase;

    always_ff @(posedge clk) begin
        if (!rst_n)
            phase <= '0;
        else if (phase == LAST_PH)
            phase <= '0;
        else
            phase <= phase + PH_W'(1);
    end

    assign tick = (phase == '0);
endmodule

// File: rtl/raster_vblank_flag.sv
module raster_vblank_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_p,
    input  logic clr_p,
    output logic flag
);
    // Setting takes priority over any clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= 1'b0;
        else if (set_p)
            flag <= 1'b1;
        else if (clr_p)
            flag <= 1'b0;
    end
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
    import raster_pkg::*;
#(
    parameter int P_DOTS      = 341,
    parameter int P_LINES     = 262,
    parameter int P_VIS_LINES = 240,
    parameter int P_DIV       = 3,
    parameter int DOT_W       = $clog2(P_DOTS),
    parameter int LINE_W      = $clog2(P_LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              render_en,
    input  logic              irq_en,
    input  logic              flag_clr,
    output logic [DOT_W-1:0]  dot,
    output logic [LINE_W-1:0] line,
    output logic              is_visible,
    output logic              is_postidle,
    output logic              is_vblank,
    output logic              is_prerender,
    output logic              vblank_flag,
    output logic              irq,
    output logic              odd_frame,
    output logic              cpu_tick
);
    localparam logic [LINE_W-1:0] LAST_VIS  = LINE_W'(P_VIS_LINES - 1);
    localparam logic [LINE_W-1:0] VBL_LINE  = LINE_W'(P_VIS_LINES + 1);
    localparam logic [LINE_W-1:0] LAST_VBL  = LINE_W'(P_LINES - 2);
    localparam logic [LINE_W-1:0] PRE_LINE  = LINE_W'(P_LINES - 1);
    localparam logic [DOT_W-1:0]  FLAG_DOT  = DOT_W'(1);

    region_t state, state_nx;
    logic    line_end;
    logic    skip_last;
    logic    set_p, clr_p;

    assign skip_last = (state == RG_PRERENDER) && odd_frame && render_en;

    raster_pos_ctr #(
        .P_DOTS(P_DOTS), .P_LINES(P_LINES), .DOT_W(DOT_W), .LINE_W(LINE_W)
    ) u_pos (
        .clk(clk), .rst_n(rst_n), .skip_last(skip_last),
        .dot(dot), .line(line), .line_end(line_end), .odd_frame(odd_frame)
    );

    raster_cpu_div #(.P_DIV(P_DIV)) u_div (
        .clk(clk), .rst_n(rst_n), .tick(cpu_tick)
    );

    // Region state machine: transitions only at a line end
    always_comb begin
        state_nx = state;
        unique case (state)
            RG_VISIBLE:   if (line_end && line == LAST_VIS) state_nx = RG_POSTIDLE;
            RG_POSTIDLE:  if (line_end)                     state_nx = RG_VBLANK;
            RG_VBLANK:    if (line_end && line == LAST_VBL) state_nx = RG_PRERENDER;
            RG_PRERENDER: if (line_end)                     state_nx = RG_VISIBLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= RG_VISIBLE;
        else
            state <= state_nx;
    end

    // Output decode
    always_comb begin
        is_visible   = 1'b0;
        is_postidle  = 1'b0;
        is_vblank    = 1'b0;
        is_prerender = 1'b0;
        unique case (state)
            RG_VISIBLE:   is_visible   = 1'b1;
            RG_POSTIDLE:  is_postidle  = 1'b1;
            RG_VBLANK:    is_vblank    = 1'b1;
            RG_PRERENDER: is_prerender = 1'b1;
        endcase
    end

    assign set_p = (state == RG_VBLANK) && (line == VBL_LINE) && (dot == FLAG_DOT);
    assign clr_p = flag_clr || ((state == RG_PRERENDER) && (line == PRE_LINE) && (dot == FLAG_DOT));

    raster_vblank_flag u_flag (
        .clk(clk), .rst_n(rst_n), .set_p(set_p), .clr_p(clr_p), .flag(vblank_flag)
    );

    assign irq = vblank_flag & irq_en;
endmodule

// File: rtl/raster_timing_chk.sv
module raster_timing_chk #(
    parameter int P_DOTS      = 341,
    parameter int P_LINES     = 262,
    parameter int P_VIS_LINES = 240,
    parameter int DOT_W       = 9,
    parameter int LINE_W      = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              render_en,
    input logic              flag_clr,
    input logic [DOT_W-1:0]  dot,
    input logic [LINE_W-1:0] line,
    input logic              is_visible,
    input logic              is_postidle,
    input logic              is_vblank,
    input logic              is_prerender,
    input logic              vblank_flag,
    input logic              irq,
    input logic              odd_frame,
    input logic              cpu_tick
);
    localparam logic [DOT_W-1:0]  SKIP_DOT = DOT_W'(P_DOTS - 2);
    localparam logic [DOT_W-1:0]  LAST_DOT = DOT_W'(P_DOTS - 1);
    localparam logic [LINE_W-1:0] VIS_N    = LINE_W'(P_VIS_LINES);
    localparam logic [LINE_W-1:0] VBL_LINE = LINE_W'(P_VIS_LINES + 1);
    localparam logic [LINE_W-1:0] PRE_LINE = LINE_W'(P_LINES - 1);

    a_r1_dot_step: assert property (@(posedge clk) disable iff (!rst_n)
        (dot != '0) |-> (dot == $past(dot) + DOT_W'(1)));
    a_r1_line_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (dot != '0) |-> $stable(line));
    a_r2_one_region: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({is_visible, is_postidle, is_vblank, is_prerender}) == 1);
    a_r2_visible_range: assert property (@(posedge clk) disable iff (!rst_n)
        is_visible |-> (line < VIS_N));
    a_r3_postidle_line: assert property (@(posedge clk) disable iff (!rst_n)
        is_postidle |-> (line == VIS_N));
    a_r4_vblank_range: assert property (@(posedge clk) disable iff (!rst_n)
        is_vblank |-> (line >= VBL_LINE && line < PRE_LINE));
    a_r5_pre_line: assert property (@(posedge clk) disable iff (!rst_n)
        is_prerender |-> (line == PRE_LINE));
    a_r6_odd_skip: assert property (@(posedge clk) disable iff (!rst_n)
        (is_prerender && odd_frame && render_en && dot == SKIP_DOT)
        |=> (dot == '0 && line == '0));
    a_r7_full_line: assert property (@(posedge clk) disable iff (!rst_n)
        (is_prerender && !(odd_frame && render_en) && dot == SKIP_DOT)
        |=> (dot == LAST_DOT));
    a_r8_parity_flip: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(is_prerender) && line == '0) |-> (odd_frame != $past(odd_frame)));
    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !(line == VBL_LINE && dot == DOT_W'(1))) |=> !vblank_flag);
    a_r11_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> vblank_flag);
    a_r12_tick_gap1: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_tick |=> !cpu_tick);
    a_r12_tick_gap2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_tick && $past(cpu_tick)) |=> !cpu_tick);
endmodule

bind raster_timing_gen raster_timing_chk #(
    .P_DOTS(P_DOTS), .P_LINES(P_LINES), .P_VIS_LINES(P_VIS_LINES),
    .DOT_W(DOT_W), .LINE_W(LINE_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .render_en(render_en), .flag_clr(flag_clr),
    .dot(dot), .line(line), .is_visible(is_visible), .is_postidle(is_postidle),
    .is_vblank(is_vblank), .is_prerender(is_prerender), .vblank_flag(vblank_flag),
    .irq(irq), .odd_frame(odd_frame), .cpu_tick(cpu_tick)
);

// File: tb/raster_timing_gen_tb_top.sv
module raster_timing_gen_tb_top;
    localparam int DOTS  = 341;
    localparam int S_DOTS = 20;

    typedef struct packed {
        int unsigned ln;
        int unsigned dt;
        logic [3:0]  rg;   // {visible, postidle, vblank, prerender}
        logic        vb;
    } vec_t;

    localparam vec_t VECS [14] = '{
        '{0,   0,   4'b1000, 1'b0},
        '{0,   340, 4'b1000, 1'b0},
        '{1,   0,   4'b1000, 1'b0},
        '{239, 340, 4'b1000, 1'b0},
        '{240, 0,   4'b0100, 1'b0},
        '{240, 340, 4'b0100, 1'b0},
        '{241, 0,   4'b0010, 1'b0},
        '{241, 1,   4'b0010, 1'b0},
        '{241, 2,   4'b0010, 1'b1},
        '{260, 340, 4'b0010, 1'b1},
        '{261, 0,   4'b0001, 1'b1},
        '{261, 1,   4'b0001, 1'b1},
        '{261, 2,   4'b0001, 1'b0},
        '{261, 340, 4'b0001, 1'b0}
    };

    logic clk = 1'b0;
    always #4 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    // Full geometry instance
    logic       rst_n = 1'b0, render_m = 1'b1, irq_en_m = 1'b1, clr_m = 1'b0;
    logic [8:0] dot_m, line_m;
    logic       vis_m, post_m, vbl_m, pre_m, flag_m, irq_m, odd_m, tick_m;

    raster_timing_gen dut_i (
        .clk(clk), .rst_n(rst_n), .render_en(render_m), .irq_en(irq_en_m),
        .flag_clr(clr_m), .dot(dot_m), .line(line_m), .is_visible(vis_m),
        .is_postidle(post_m), .is_vblank(vbl_m), .is_prerender(pre_m),
        .vblank_flag(flag_m), .irq(irq_m), .odd_frame(odd_m), .cpu_tick(tick_m)
    );

    // Reduced geometry instance: 12 lines x 20 dots, 6 shown lines
    logic       rst_s_n = 1'b0, render_s = 1'b1, irq_en_s = 1'b1, clr_s = 1'b0;
    logic [4:0] dot_s;
    logic [3:0] line_s;
    logic       vis_s, post_s, vbl_s, pre_s, flag_s, irq_s, odd_s, tick_s;

    raster_timing_gen #(.P_DOTS(S_DOTS), .P_LINES(12), .P_VIS_LINES(6)) dut_small_i (
        .clk(clk), .rst_n(rst_s_n), .render_en(render_s), .irq_en(irq_en_s),
        .flag_clr(clr_s), .dot(dot_s), .line(line_s), .is_visible(vis_s),
        .is_postidle(post_s), .is_vblank(vbl_s), .is_prerender(pre_s),
        .vblank_flag(flag_s), .irq(irq_s), .odd_frame(odd_s), .cpu_tick(tick_s)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
        end
    endtask

    task automatic goto(input int target);
        while (cyc < target) begin
            @(posedge clk);
            #1;
            cyc++;
        end
    endtask

    task automatic chk_small_pos(input string req, input int ln, input int dt, input int od);
        chk(int'(line_s) == ln, req, int'(line_s), ln);
        chk(int'(dot_s)  == dt, req, int'(dot_s), dt);
        chk(int'(odd_s)  == od, req, int'(odd_s), od);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R13 reset state
        chk(line_m == 0 && dot_m == 0, "R13", int'(dot_m), 0);
        chk({vis_m, post_m, vbl_m, pre_m} == 4'b1000, "R13", int'({vis_m, post_m, vbl_m, pre_m}), 8);
        chk(!flag_m && !irq_m && !odd_m, "R13", int'({flag_m, irq_m, odd_m}), 0);
        chk(tick_m, "R13", int'(tick_m), 1);

        rst_n = 1'b1;
        cyc = 0;
        // Table walk through the first (even) frame
        foreach (VECS[i]) begin
            goto(int'(VECS[i].ln) * DOTS + int'(VECS[i].dt));
            chk(int'(line_m) == int'(VECS[i].ln), "R1", int'(line_m), int'(VECS[i].ln));
            chk(int'(dot_m)  == int'(VECS[i].dt), "R1", int'(dot_m), int'(VECS[i].dt));
            // R2 R3 R4 R5 region flags
            chk({vis_m, post_m, vbl_m, pre_m} == VECS[i].rg, "R2_R3_R4_R5",
                int'({vis_m, post_m, vbl_m, pre_m}), int'(VECS[i].rg));
            chk(flag_m == VECS[i].vb, "R9", int'(flag_m), int'(VECS[i].vb));
            chk(irq_m == VECS[i].vb, "R11", int'(irq_m), int'(VECS[i].vb));
            chk(tick_m == ((cyc % 3) == 0), "R12", int'(tick_m), int'((cyc % 3) == 0));
            chk(!odd_m, "R8", int'(odd_m), 0);
        end
        // R7: even frame kept dot 340; wrap follows
        goto(262 * DOTS);
        chk(line_m == 0 && dot_m == 0, "R1", int'(line_m), 0);
        chk(odd_m, "R8", int'(odd_m), 1);

        // Reduced geometry scenarios
        rst_s_n = 1'b1;
        cyc = 0;
        goto(239); chk_small_pos("R7", 11, 19, 0);
        goto(240); chk_small_pos("R8", 0, 0, 1);
        goto(478); chk_small_pos("R6", 11, 18, 1);
        goto(479); chk_small_pos("R6", 0, 0, 0);
        goto(621);
        chk(flag_s, "R9", int'(flag_s), 1);
        chk(irq_s, "R11", int'(irq_s), 1);
        chk(tick_s == ((cyc % 3) == 0), "R12", int'(tick_s), int'((cyc % 3) == 0));
        irq_en_s = 1'b0;
        #1;
        chk(!irq_s, "R11", int'(irq_s), 0);
        clr_s = 1'b1;
        goto(622);
        clr_s = 1'b0;
        chk(!flag_s, "R10", int'(flag_s), 0);
        chk(!irq_s, "R11", int'(irq_s), 0);
        render_s = 1'b0;
        irq_en_s = 1'b1;
        goto(861);
        chk(flag_s && irq_s, "R9", int'(flag_s), 1);
        goto(940);
        chk(flag_s, "R9", int'(flag_s), 1);
        goto(941);
        chk(!flag_s, "R9", int'(flag_s), 0);
        goto(958); chk_small_pos("R7", 11, 19, 1);
        goto(959); chk_small_pos("R8", 0, 0, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog at cycle %0d: actual running expected done", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule